// File: doc/BRIEF.md
# Shader Clause Boundary Former

The block sits in the front end of a shader sequencer. It receives a shader program as a stream of instruction slots and decides where each execution clause has to stop. Every slot reports how many scalar operations it carries and how many literal constant words come with it. One clause may hold a limited number of slots. It may also hold a limited number of code words, and operations and literals draw on that same word budget. The clause closes as soon as either budget would overflow. A slot is never split across two clauses.

Each slot leaves the block unchanged, with three added tags: a first-of-clause flag, a last-of-clause flag and an 8-bit clause index. An incoming slot can only be placed once the next slot (or a program end) is known. For that reason the block keeps one slot in a hold register until the end decision for it is made. A clause that fills a budget exactly is closed on its final slot at once, without waiting for the next slot. Both ports use a valid/ready handshake, and the output is registered.

Top module: `clause_former`

## Requirements
- R1: A clause never contains more than 32 slots. A clause that reaches 32 slots has its 32nd slot marked last, and the next slot is marked first.
- R2: Each slot charges a word cost of operations plus literals against a clause budget of 128 words. When an incoming slot would push the clause past 128 words, the previously emitted slot is marked last and the incoming slot is marked first of a new clause.
- R3: Every slot is emitted exactly once, in order, with its operation and literal counts unchanged. The first flag is set exactly on the slot that follows a slot with the last flag set, and on the very first slot after reset.
- R4: A slot presented with the program-end input high is marked last. The following slot starts a new clause with empty budgets.
- R5: All slots of one clause carry the same clause index. The index is 0 for the first clause after reset, rises by one for each closed clause, and wraps from 255 to 0.
- R6: The error output is high on a slot whose operation count exceeds 5 (encodings 6 and 7) or whose literal count exceeds 2 (encoding 3). Such a slot is still forwarded and charged its raw word cost.
- R7: While out_valid is high and out_ready is low, all output fields hold their values. Random backpressure neither loses nor duplicates slots.
- R8: In the cycle after synchronous reset is released, out_valid is low and in_ready is high.
- R9: A slot that brings its clause to exactly 32 slots or exactly 128 words is emitted without any further input. A slot whose clause is still open is held until the next slot or a program end arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input slot present |
| in_ready | output | 1 | Block accepts the input slot this cycle |
| in_ops | input | 3 | Scalar operations in the slot (1..5 legal) |
| in_lits | input | 2 | Literal words in the slot (0..2 legal) |
| in_prog_end | input | 1 | This slot is the last of the program |
| out_valid | output | 1 | Output slot present |
| out_ready | input | 1 | Consumer takes the output slot |
| out_ops | output | 3 | Forwarded operation count |
| out_lits | output | 2 | Forwarded literal count |
| out_first | output | 1 | Slot opens a clause |
| out_last | output | 1 | Slot closes a clause |
| out_idx | output | 8 | Clause index |
| out_err | output | 1 | Slot counts out of legal range |

## Verification
Runs of single-operation slots reach the slot cap before the word budget. Runs of heavy slots (seven words each) reach the word budget at 18 slots, and four-word slots hit both limits on the same slot. These cases tell the two budgets apart. A pseudo-random mix of operation and literal counts under random output backpressure shows that boundaries land correctly when both budgets are partly used and the hold register stalls. Short programs, many single-slot programs running the index past 255, out-of-range counts, and an exact 128-word fill followed by an open clause left idle cover program end, wrap, error marking, and eager versus held emission.

// File: rtl/clause_pkg.sv
`timescale 1ns/1ps
package clause_pkg;
  localparam int OPS_W = 3;
  localparam int LIT_W = 2;
  localparam int IDX_W = 8;

  typedef struct packed {
    logic [OPS_W-1:0] ops;
    logic [LIT_W-1:0] lits;
    logic             err;
    logic             first;
    logic             last;
    logic [IDX_W-1:0] idx;
  } slot_t;
endpackage

// File: rtl/clause_budget.sv
`timescale 1ns/1ps
module clause_budget
  import clause_pkg::*;
#(
  parameter int MAX_SLOTS = 32,
  parameter int MAX_WORDS = 128,
  parameter int MAX_OPS   = 5,
  parameter int MAX_LITS  = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             take,
  input  logic [OPS_W-1:0] in_ops,
  input  logic [LIT_W-1:0] in_lits,
  input  logic             in_end,
  output slot_t            s_slot,
  output logic             close_prev
);
  localparam int SC_W  = $clog2(MAX_SLOTS + 1);
  localparam int WC_W  = $clog2(MAX_WORDS + 1);
  localparam int SUM_W = WC_W + 1;

  logic             open;
  logic [SC_W-1:0]  cnt_s;
  logic [WC_W-1:0]  cnt_w;
  logic [IDX_W-1:0] cur_idx;

  logic [SUM_W-1:0] slot_w, sum_w, nxt_w;
  logic [SC_W-1:0]  nxt_s;
  logic             fits, first, close_now;

  // Fit test of the incoming slot against the open clause.
  always_comb begin
    slot_w     = SUM_W'(in_ops) + SUM_W'(in_lits);
    sum_w      = SUM_W'(cnt_w) + slot_w;
    fits       = (cnt_s < SC_W'(MAX_SLOTS)) && (sum_w <= SUM_W'(MAX_WORDS));
    close_prev = open && !fits;
    first      = !open || !fits;
    nxt_s      = (first ? '0 : cnt_s) + SC_W'(1);
    nxt_w      = (first ? '0 : SUM_W'(cnt_w)) + slot_w;
    close_now  = in_end || (nxt_s == SC_W'(MAX_SLOTS)) ||
                 (nxt_w >= SUM_W'(MAX_WORDS));

    s_slot.ops   = in_ops;
    s_slot.lits  = in_lits;
    s_slot.err   = (in_ops > OPS_W'(MAX_OPS)) || (in_lits > LIT_W'(MAX_LITS));
    s_slot.first = first;
    s_slot.last  = close_now;
    s_slot.idx   = close_prev ? cur_idx + IDX_W'(1) : cur_idx;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      open    <= 1'b0;
      cnt_s   <= '0;
      cnt_w   <= '0;
      cur_idx <= '0;
    end else if (take) begin
      open    <= !close_now;
      cnt_s   <= close_now ? '0 : nxt_s;
      cnt_w   <= close_now ? '0 : WC_W'(nxt_w);
      cur_idx <= close_now ? s_slot.idx + IDX_W'(1) : s_slot.idx;
    end
  end

  AST_SLOT_CAP: assert property (@(posedge clk) disable iff (rst)
    open |-> (cnt_s < SC_W'(MAX_SLOTS)));  // R1
  AST_WORD_CAP: assert property (@(posedge clk) disable iff (rst)
    open |-> (cnt_w < WC_W'(MAX_WORDS)));  // R2
  AST_PROG_END_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (take && in_end) |=> (!open && cnt_s == '0 && cnt_w == '0));  // R4
  AST_IDX_ADVANCE: assert property (@(posedge clk) disable iff (rst)
    (take && s_slot.last) |=> (cur_idx == $past(s_slot.idx) + IDX_W'(1)));  // R5
endmodule

// File: rtl/slot_hold.sv
`timescale 1ns/1ps
module slot_hold
  import clause_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  in_valid,
  output logic  in_ready,
  output logic  take,
  input  slot_t new_slot,
  input  logic  close_prev,
  input  logic  o_free,
  output logic  move,
  output slot_t mv_slot
);
  logic  hv;
  slot_t held;

  assign in_ready = !hv || o_free;
  assign take     = in_valid && in_ready;
  // A held slot leaves once its end is decided: already closed, or a new slot arrives.
  assign move     = hv && (held.last || take) && o_free;

  always_comb begin
    mv_slot      = held;
    mv_slot.last = held.last | (take & close_prev);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hv   <= 1'b0;
      held <= '0;
    end else if (take) begin
      hv   <= 1'b1;
      held <= new_slot;
    end else if (move) begin
      hv   <= 1'b0;
    end
  end

  AST_HOLD_KEEPS: assert property (@(posedge clk) disable iff (rst)
    (hv && !move) |=> (hv && $stable(held)));  // R7
  AST_NO_SPLIT: assert property (@(posedge clk) disable iff (rst)
    (take && hv) |-> move);  // R3
endmodule

// File: rtl/slot_out_stage.sv
`timescale 1ns/1ps
module slot_out_stage
  import clause_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  move,
  input  slot_t mv_slot,
  input  logic  out_ready,
  output logic  o_free,
  output logic  out_valid,
  output slot_t out_slot
);
  assign o_free = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_slot  <= '0;
    end else if (move) begin
      out_valid <= 1'b1;
      out_slot  <= mv_slot;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  // History of the last forwarded slot, used only by the checks below.
  logic             seen, prev_last;
  logic [IDX_W-1:0] prev_idx;
  always_ff @(posedge clk) begin
    if (rst) begin
      seen      <= 1'b0;
      prev_last <= 1'b0;
      prev_idx  <= '0;
    end else if (move) begin
      seen      <= 1'b1;
      prev_last <= mv_slot.last;
      prev_idx  <= mv_slot.idx;
    end
  end

  AST_RESET_IDLE: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !out_valid);  // R8
  AST_OUT_STABLE: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_slot)));  // R7
  AST_FIRST_AFTER_LAST: assert property (@(posedge clk) disable iff (rst)
    (move && seen) |-> (mv_slot.first == prev_last));  // R3
  AST_IDX_SAME: assert property (@(posedge clk) disable iff (rst)
    (move && seen && !prev_last) |-> (mv_slot.idx == prev_idx));  // R5
  AST_IDX_STEP: assert property (@(posedge clk) disable iff (rst)
    (move && seen && prev_last) |-> (mv_slot.idx == prev_idx + IDX_W'(1)));  // R5
endmodule

// File: rtl/clause_former.sv
`timescale 1ns/1ps
module clause_former
  import clause_pkg::*;
#(
  parameter int MAX_SLOTS = 32,
  parameter int MAX_WORDS = 128,
  parameter int MAX_OPS   = 5,
  parameter int MAX_LITS  = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [OPS_W-1:0] in_ops,
  input  logic [LIT_W-1:0] in_lits,
  input  logic             in_prog_end,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [OPS_W-1:0] out_ops,
  output logic [LIT_W-1:0] out_lits,
  output logic             out_first,
  output logic             out_last,
  output logic [IDX_W-1:0] out_idx,
  output logic             out_err
);
  logic  take, close_prev, move, o_free;
  slot_t new_slot, mv_slot, out_slot;

  clause_budget #(
    .MAX_SLOTS(MAX_SLOTS), .MAX_WORDS(MAX_WORDS),
    .MAX_OPS(MAX_OPS), .MAX_LITS(MAX_LITS)
  ) u_budget (
    .clk(clk), .rst(rst), .take(take),
    .in_ops(in_ops), .in_lits(in_lits), .in_end(in_prog_end),
    .s_slot(new_slot), .close_prev(close_prev)
  );

  slot_hold u_hold (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .take(take), .new_slot(new_slot), .close_prev(close_prev),
    .o_free(o_free), .move(move), .mv_slot(mv_slot)
  );

  slot_out_stage u_out (
    .clk(clk), .rst(rst), .move(move), .mv_slot(mv_slot),
    .out_ready(out_ready), .o_free(o_free),
    .out_valid(out_valid), .out_slot(out_slot)
  );

  assign out_ops   = out_slot.ops;
  assign out_lits  = out_slot.lits;
  assign out_first = out_slot.first;
  assign out_last  = out_slot.last;
  assign out_idx   = out_slot.idx;
  assign out_err   = out_slot.err;

  AST_ERR_MARK: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_err == ((out_ops > OPS_W'(MAX_OPS)) ||
                               (out_lits > LIT_W'(MAX_LITS)))));  // R6
endmodule

// File: tb/clause_former_test.sv
`timescale 1ns/1ps
module clause_former_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       in_valid = 1'b0, in_prog_end = 1'b0, out_ready = 1'b0;
  logic [2:0] in_ops = '0;
  logic [1:0] in_lits = '0;
  logic       in_ready, out_valid, out_first, out_last, out_err;
  logic [2:0] out_ops;
  logic [1:0] out_lits;
  logic [7:0] out_idx;

  clause_former uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_ops(in_ops), .in_lits(in_lits), .in_prog_end(in_prog_end),
    .out_valid(out_valid), .out_ready(out_ready), .out_ops(out_ops),
    .out_lits(out_lits), .out_first(out_first), .out_last(out_last),
    .out_idx(out_idx), .out_err(out_err)
  );

  always #2.5 clk = ~clk;

  int total = 0, bad = 0;

  // Slot queue and expected tags, built from the requirements.
  logic [2:0] q_ops  [0:2047];
  logic [1:0] q_lits [0:2047];
  logic       q_last [0:2047];
  logic       e_first[0:2047];
  logic       e_last [0:2047];
  logic       e_err  [0:2047];
  logic [7:0] e_idx  [0:2047];
  int n_q = 0, n_sent = 0, n_recv = 0;
  logic       m_open = 1'b0;
  int         m_s = 0, m_w = 0;
  logic [7:0] m_idx = '0;
  logic [15:0] lfsr = 16'hACE1;

  task automatic step_lfsr();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
  endtask

  task automatic chk(input logic ok, input string req, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic add(input int ops, input int lits, input logic last);
    int w = ops + lits;
    if (m_open && (m_s >= 32 || m_w + w > 128)) begin
      e_last[n_q-1] = 1'b1;
      m_open = 1'b0;
      m_idx++;
    end
    if (!m_open) begin m_s = 0; m_w = 0; end
    e_first[n_q] = !m_open;
    m_s++;
    m_w += w;
    e_idx[n_q]  = m_idx;
    e_err[n_q]  = (ops > 5) || (lits > 2);
    e_last[n_q] = 1'b0;
    m_open = 1'b1;
    if (last || m_s == 32 || m_w >= 128) begin
      e_last[n_q] = 1'b1;
      m_open = 1'b0;
      m_idx++;
    end
    q_ops[n_q]  = 3'(ops);
    q_lits[n_q] = 2'(lits);
    q_last[n_q] = last;
    n_q++;
  endtask

  task automatic compare_out(input string tag);
    int k = n_recv;
    if (k >= n_q) begin
      chk(1'b0, "R3", $sformatf("%s extra slot", tag), k, n_q);
      return;
    end
    chk(out_first == e_first[k], "R3", $sformatf("%s slot %0d first", tag, k), out_first, e_first[k]);
    chk(out_last == e_last[k], "R3", $sformatf("%s slot %0d last", tag, k), out_last, e_last[k]);
    chk(out_idx == e_idx[k], "R5", $sformatf("%s slot %0d index", tag, k), out_idx, e_idx[k]);
    chk(out_ops == q_ops[k] && out_lits == q_lits[k], "R3",
        $sformatf("%s slot %0d counts", tag, k), {out_ops, out_lits}, {q_ops[k], q_lits[k]});
    chk(out_err == e_err[k], "R6", $sformatf("%s slot %0d error", tag, k), out_err, e_err[k]);
  endtask

  // Drive queued slots and collect outputs until target outputs have arrived.
  task automatic run(input string tag, input logic bp, input int target);
    int guard = 0;
    while ((n_sent < n_q || n_recv < target) && guard < 20000) begin
      @(negedge clk);
      step_lfsr();
      out_ready = bp ? lfsr[3] : 1'b1;
      if (n_sent < n_q) begin
        in_valid = 1'b1;
        in_ops = q_ops[n_sent];
        in_lits = q_lits[n_sent];
        in_prog_end = q_last[n_sent];
      end else begin
        in_valid = 1'b0;
      end
      #0.5;
      if (out_valid && out_ready) begin
        compare_out(tag);
        n_recv++;
      end
      if (in_valid && in_ready) n_sent++;
      guard++;
    end
    @(negedge clk);
    in_valid = 1'b0;
    out_ready = 1'b0;
    chk(guard < 20000, tag, "run completion", n_recv, target);
  endtask

  // Idle with ready high; nothing beyond expect_cnt may appear.
  task automatic idle_check(input string tag, input int cycles, input int expect_cnt);
    in_valid = 1'b0;
    out_ready = 1'b1;
    for (int c = 0; c < cycles; c++) begin
      @(negedge clk);
      #0.5;
      if (out_valid && out_ready) begin
        compare_out(tag);
        n_recv++;
      end
    end
    out_ready = 1'b0;
    chk(n_recv == expect_cnt, tag, "output count after idle", n_recv, expect_cnt);
  endtask

  task automatic t_reset();
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    #0.5;
    chk(out_valid == 1'b0, "R8", "out_valid after reset", out_valid, 0);
    chk(in_ready == 1'b1, "R8", "in_ready after reset", in_ready, 1);
  endtask

  task automatic t_slot_cap();  // R1: 32 + 32 + 6
    for (int i = 0; i < 70; i++) add(1, 0, i == 69);
    run("R1", 1'b0, n_q);
  endtask

  task automatic t_word_cap();  // R2: 7-word slots close at 18, 4-word slots hit both caps
    for (int i = 0; i < 40; i++) add(5, 2, i == 39);
    for (int i = 0; i < 33; i++) add(4, 0, i == 32);
    run("R2", 1'b0, n_q);
  endtask

  task automatic t_mixed_bp();  // R7: random counts under backpressure
    for (int i = 0; i < 120; i++) begin
      step_lfsr();
      add(1 + int'(lfsr[7:0]) % 5, int'(lfsr[15:8]) % 3, i == 119);
    end
    run("R7", 1'b1, n_q);
  endtask

  task automatic t_prog_end();  // R4: short programs
    add(2, 1, 1'b0); add(3, 0, 1'b0); add(1, 2, 1'b1);
    add(5, 0, 1'b1);
    add(1, 1, 1'b0); add(2, 2, 1'b1);
    run("R4", 1'b0, n_q);
  endtask

  task automatic t_exact_fill();  // R9: 16 x 8 words = 128, then an open clause
    for (int i = 0; i < 16; i++) add(5, 3, 1'b0);
    run("R9", 1'b0, n_q);
    idle_check("R9", 8, n_q);
    for (int i = 0; i < 5; i++) add(1, 0, 1'b0);
    run("R9", 1'b0, n_q - 1);
    idle_check("R9", 10, n_q - 1);
    add(2, 1, 1'b1);
    run("R4", 1'b0, n_q);
  endtask

  task automatic t_errors();  // R6
    add(6, 0, 1'b0); add(7, 3, 1'b0); add(5, 2, 1'b0); add(1, 3, 1'b0);
    add(3, 1, 1'b1);
    run("R6", 1'b0, n_q);
  endtask

  task automatic t_wrap();  // R5: index passes 255
    for (int i = 0; i < 260; i++) add(1 + i % 5, i % 3, 1'b1);
    run("R5", 1'b1, n_q);
  endtask

  initial begin
    t_reset();
    t_slot_cap();
    t_word_cap();
    t_mixed_bp();
    t_prog_end();
    t_exact_fill();
    t_errors();
    t_wrap();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=%0d expected=%0d", n_recv, n_q);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule